// File: doc/BRIEF.md
# Byte-Addressable Seconds Timekeeper

This block keeps a 32-bit count of whole seconds since midnight at the start of 1 January 1904. It runs in the fast system clock domain. A 32.768 kHz reference enters as a single-cycle strobe, `ref_tick`. The block divides that strobe by 64 to give a 512 Hz rate. It then counts 256 of those steps to mark each half second, and a one-bit phase flag lets every second half-second mark advance the count by one.

A serial command front end reads and writes the count one byte at a time through a small lane port. A two-bit lane selects a byte, with lane 0 as the least significant byte. Reads are combinational from the single count register. A lane write is merged into the count in the same register update as any increment, so a byte access never sees or leaves a half-updated value, and no second is lost.

Top module: `secs_timekeeper`

## Requirements
- R1: After reset the count is 0x967A7600, which is 20 × 1461 days of seconds, or 1 January 1984. The prescaler, the half-second counter and the phase flag all start at zero.
- R2: `lane_rdata` shows byte `lane_sel` of the count in the same cycle. Lane 0 is bits 7:0, lane 1 is bits 15:8, lane 2 is bits 23:16 and lane 3 is bits 31:24.
- R3: A cycle with `lane_wr` high replaces only the selected byte with `lane_wdata`. The other three bytes keep their values, and the new value is readable from the next cycle.
- R4: Cycles with `ref_tick` low and `lane_wr` low change nothing. The count stays the same and no reference tick is counted.
- R5: The count rises by exactly one on every 32768th `ref_tick` since reset, and only then. The half-second mark at the 16384th tick leaves the count unchanged.
- R6: When a lane write and an increment fall in the same cycle, the count becomes the written value plus one.
- R7: An increment from 0xFFFFFFFF gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle strobe per reference period (32768 per second) |
| lane_sel | input | 2 | Byte lane for read and write, 0 = least significant |
| lane_wr | input | 1 | Write `lane_wdata` into the selected lane |
| lane_wdata | input | 8 | Byte to write |
| lane_rdata | output | 8 | Selected byte of the count |

## Verification
The assertions assume that `ref_tick` is a clean strobe sampled at most once per system clock. They also assume that the lane inputs are stable around each rising edge. The bench drives every input on the falling edge, so each tick and each write is seen by exactly one rising edge. The bench counts ticks exactly from reset, which lets it place a lane write on the very edge that carries the 32768th tick and check the merge-then-increment result. Reads are sampled within the low half of the clock, when no edge can intervene.

// File: rtl/secs_timekeeper.sv
module secs_timekeeper #(
  parameter int          PRE_DIV   = 64,
  parameter int          HALF_DIV  = 256,
  parameter logic [31:0] EPOCH_SEC = 32'(64'd86400 * 64'd1461 * 64'd20)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic [1:0] lane_sel,
  input  logic       lane_wr,
  input  logic [7:0] lane_wdata,
  output logic [7:0] lane_rdata
);
  localparam int PW = $clog2(PRE_DIV);
  localparam int HW = $clog2(HALF_DIV);

  logic [PW-1:0] pre_cnt;
  logic [HW-1:0] half_cnt;
  logic          phase;
  logic [31:0]   secs;
  logic [31:0]   merged;

  wire pre_wrap = ref_tick && (pre_cnt == PW'(PRE_DIV - 1));
  wire half_evt = pre_wrap && (half_cnt == HW'(HALF_DIV - 1));
  wire sec_inc  = half_evt && phase;

  always_comb begin
    merged = secs;
    if (lane_wr) merged[{lane_sel, 3'b000} +: 8] = lane_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      half_cnt <= '0;
      phase    <= 1'b0;
      secs     <= EPOCH_SEC;
    end else begin
      if (ref_tick) pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_wrap) half_cnt <= half_evt ? '0 : half_cnt + 1'b1;
      if (half_evt) phase <= ~phase;
      secs <= merged + {31'd0, sec_inc};
    end
  end

  assign lane_rdata = secs[{lane_sel, 3'b000} +: 8];
endmodule

// File: rtl/secs_timekeeper_chk.sv
module secs_timekeeper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ref_tick,
  input logic [1:0]  lane_sel,
  input logic        lane_wr,
  input logic [7:0]  lane_wdata,
  input logic [31:0] secs
);
  p_reset_value_r1: assert property (@(posedge clk) $rose(rst_n) |-> secs == 32'h967A7600)
    else $error("reset value wrong");

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_tick && !lane_wr) |=> $stable(secs))
    else $error("count moved while idle");

  p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_wr |=> (secs == $past(secs) || secs == $past(secs) + 32'd1))
    else $error("count stepped by more than one");

  p_lane_merge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lane_wr |=>
      (secs == (($past(secs) & ~(32'hFF << {$past(lane_sel), 3'b000})) |
                ({24'd0, $past(lane_wdata)} << {$past(lane_sel), 3'b000}))) ||
      (secs == (($past(secs) & ~(32'hFF << {$past(lane_sel), 3'b000})) |
                ({24'd0, $past(lane_wdata)} << {$past(lane_sel), 3'b000})) + 32'd1))
    else $error("lane write merge wrong");

  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!lane_wr && secs == 32'hFFFF_FFFF) |=> (secs == 32'hFFFF_FFFF || secs == 32'd0))
    else $error("wrap wrong");
endmodule

bind secs_timekeeper secs_timekeeper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .lane_sel(lane_sel),
  .lane_wr(lane_wr), .lane_wdata(lane_wdata), .secs(secs)
);

// File: tb/tb_secs_timekeeper.sv
module tb_secs_timekeeper;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS_PER_SEC = 32768;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic [1:0] lane_sel = 2'd0;
  logic       lane_wr = 1'b0;
  logic [7:0] lane_wdata = 8'd0;
  logic [7:0] lane_rdata;

  int checks = 0;
  int errors = 0;
  longint epoch_l;
  logic [31:0] epoch;

  secs_timekeeper dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .lane_sel(lane_sel),
    .lane_wr(lane_wr), .lane_wdata(lane_wdata), .lane_rdata(lane_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ref_tick = 1'b0; lane_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic read_all(output logic [31:0] v);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      lane_sel = 2'(i);
      #1;
      v[i*8 +: 8] = lane_rdata;
    end
  endtask

  task automatic write_lane(input logic [1:0] l, input logic [7:0] d);
    @(negedge clk);
    lane_sel = l; lane_wdata = d; lane_wr = 1'b1;
    @(negedge clk);
    lane_wr = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    ref_tick = 1'b1;
    repeat (n) @(negedge clk);
    ref_tick = 1'b0;
  endtask

  task automatic t_reset_and_read();
    logic [31:0] v;
    do_reset();
    read_all(v);
    check32("R1 reset count", v, epoch);
    @(negedge clk); lane_sel = 2'd0; #1;
    check32("R2 lane0 low byte", {24'd0, lane_rdata}, {24'd0, epoch[7:0]});
    lane_sel = 2'd3; #1;
    check32("R2 lane3 high byte", {24'd0, lane_rdata}, {24'd0, epoch[31:24]});
  endtask

  task automatic t_lane_write();
    logic [31:0] v;
    do_reset();
    write_lane(2'd2, 8'h55);
    read_all(v);
    check32("R3 write lane2 only", v, {epoch[31:24], 8'h55, epoch[15:0]});
    write_lane(2'd0, 8'hA3);
    read_all(v);
    check32("R3 write lane0 only", v, {epoch[31:24], 8'h55, epoch[15:8], 8'hA3});
  endtask

  task automatic t_idle_and_seconds();
    logic [31:0] v;
    do_reset();
    run_ticks(100);
    repeat (500) @(negedge clk);
    read_all(v);
    check32("R4 idle cycles no change", v, epoch);
    run_ticks(TICKS_PER_SEC/2 - 100);
    read_all(v);
    check32("R5 half second no step", v, epoch);
    repeat (300) @(negedge clk);
    run_ticks(TICKS_PER_SEC/2 - 1);
    read_all(v);
    check32("R4 R5 gaps not counted, one tick short", v, epoch);
    run_ticks(1);
    read_all(v);
    check32("R5 step at 32768th tick", v, epoch + 32'd1);
  endtask

  task automatic t_collision();
    logic [31:0] v;
    do_reset();
    run_ticks(TICKS_PER_SEC - 1);
    @(negedge clk);
    ref_tick = 1'b1; lane_wr = 1'b1; lane_sel = 2'd0; lane_wdata = 8'hFF;
    @(negedge clk);
    ref_tick = 1'b0; lane_wr = 1'b0;
    read_all(v);
    check32("R6 write plus increment", v, {epoch[31:8], 8'hFF} + 32'd1);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    do_reset();
    for (int i = 0; i < 4; i++) write_lane(2'(i), 8'hFF);
    read_all(v);
    check32("R3 all lanes written", v, 32'hFFFF_FFFF);
    run_ticks(TICKS_PER_SEC);
    read_all(v);
    check32("R7 wrap to zero", v, 32'd0);
  endtask

  initial begin
    epoch_l = 64'd20 * 64'd1461 * 64'd24 * 64'd3600;
    epoch = epoch_l[31:0];
    t_reset_and_read();
    t_lane_write();
    t_idle_and_seconds();
    t_collision();
    t_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule